// File: doc/BRIEF.md
# Lookahead SDRAM Read Command Scheduler

This block turns a stream of read requests into a legal command sequence for a DDR2-style memory. Each request names a bank, a row, a starting column and a transfer size. Accepted requests wait in a four-entry queue that keeps their arrival order. In every clock cycle the scheduler produces exactly one command: no-operation, activate, read or precharge. It tracks which row is open in each bank and runs its own timers, so every command it issues meets the minimum delays of the device.

The oldest request always gets the first chance. When its next command is held back by a timer, the scheduler looks at the younger requests in age order. It gives a precharge or an activate to the first of them that can legally take one and whose bank no older request is still waiting on. This prepares rows for later requests while the oldest one waits. Reads are never issued early: data bursts come out strictly in request order.

The command outputs are combinational and reflect the current state. A downstream physical layer registers them.

Top module: `lookahead_cmd_sched`

## Requirements
- R1: A queued request whose bank already has its row open is served with READ commands only, on that bank.
- R2: A request whose bank holds a different open row receives PRE, then ACT with its row, then its READs. A request whose bank is closed starts with ACT. A READ is only ever issued to a bank whose open row is the row of the request being served.
- R3: Per bank, an ACT comes at least T_RP cycles after that bank's PRE. A READ comes at least T_RCD cycles after the bank's ACT. A PRE comes at least T_RAS cycles after the bank's ACT.
- R4: Any two ACT commands, on any banks, are at least T_RRD cycles apart.
- R5: Any two READs are at least BURST_LEN/2 cycles apart. Consecutive bursts of one request come exactly BURST_LEN/2 cycles apart.
- R6: Size code s (0..3, meaning 8, 16, 32 or 64 bytes) produces 2^s READ bursts. Burst k carries column address col + k*BURST_LEN.
- R7: When the oldest request's next command is legal in a cycle, that command is issued in that cycle.
- R8: When the oldest request is blocked, the oldest younger request is chosen whose next command is PRE or ACT, is legal now, and whose bank no older queued request uses. That request receives its command.
- R9: READ commands are issued only for the oldest request, so bursts leave in request order.
- R10: The queue holds four requests. reqReady is low exactly when four are queued. A request leaves the queue in the cycle its last READ is issued, and the others keep their order.
- R11: While reset is asserted the output is NOP, reqReady is high and all banks count as closed.
- R12: cmdCode uses NOP=0, ACT=1, READ=2, PRE=3. cmdAddr carries the row for ACT, the column for READ and zero for PRE. cmdBank and cmdAddr are zero on NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The queue can take a request this cycle |
| reqBank | input | 2 | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Starting column |
| reqSize | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bytes |
| cmdCode | output | 3 | Command issued this cycle |
| cmdBank | output | 2 | Bank of the command |
| cmdAddr | output | max(ROW_W,COL_W) | Row or column of the command |

## Verification
The bench first opens a row in every bank. It then replays a four-request mix of hits and misses, like the one the scheduler is built for, followed by back-to-back misses on one bank and a long 64-byte transfer. A scheduler that gave advance work to a younger request on a bank an older request still needs would close a row before its READ; this shows up as a READ on a wrong row or as a command mismatch. A scheduler that searched youngest-first, or let a younger READ overtake, would break the burst order against the expected stream. Off-by-one errors in the countdown timers appear as commands issued one cycle early or late against a reference model that counts elapsed cycles.

// File: rtl/lasched_pkg.sv
package lasched_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int SIZE_W    = 2;
  // index of a burst within the largest transfer (2^(2^SIZE_W - 1) bursts)
  localparam int BURST_W   = (1 << SIZE_W) - 1;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_READ = 3'd2,
    CMD_PRE  = 3'd3
  } cmd_e;

  // control -> datapath strobes
  typedef struct packed {
    cmd_e              kind;
    logic [BANK_W-1:0] bank;
    logic              nextBurst;
    logic              pop;
  } strobe_t;
endpackage

// File: rtl/lasched_datapath.sv
module lasched_datapath
  import lasched_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int SLOT_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 6,
  parameter int T_RRD  = 2,
  parameter int T_CCD  = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  output logic                               reqReady,
  input  logic [BANK_W-1:0]                  reqBank,
  input  logic [ROW_W-1:0]                   reqRow,
  input  logic [COL_W-1:0]                   reqCol,
  input  logic [SIZE_W-1:0]                  reqSize,
  input  strobe_t                            strobe,
  input  logic [SLOT_W-1:0]                  slot,
  output logic [QDEPTH-1:0]                  qValid,
  output logic [QDEPTH-1:0][BANK_W-1:0]      qBank,
  output logic [QDEPTH-1:0][ROW_W-1:0]       qRow,
  output logic [COL_W-1:0]                   headCol,
  output logic [SIZE_W-1:0]                  headSize,
  output logic [BURST_W-1:0]                 burstIdx,
  output logic [NUM_BANKS-1:0]               bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]    bankRow,
  output logic [NUM_BANKS-1:0]               actOk,
  output logic [NUM_BANKS-1:0]               readOk,
  output logic [NUM_BANKS-1:0]               preOk
);
  localparam int TMAX_A = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TMAX_B = (T_RAS > T_RRD) ? T_RAS : T_RRD;
  localparam int TMAX_C = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMAX   = (TMAX_C > T_CCD) ? TMAX_C : T_CCD;
  localparam int CNT_W  = $clog2(TMAX + 1);
  localparam int CNT_Q  = $clog2(QDEPTH + 1);

  logic [CNT_Q-1:0]                 count;
  logic                             push, pop;
  logic [SLOT_W-1:0]                pushIdx;
  logic [QDEPTH-1:0][COL_W-1:0]     qCol;
  logic [QDEPTH-1:0][SIZE_W-1:0]    qSize;
  logic [CNT_W-1:0]                 rrdCnt, ccdCnt;

  assign reqReady = (count < CNT_Q'(QDEPTH));
  assign push     = reqValid && reqReady;
  assign pop      = strobe.pop;
  assign pushIdx  = SLOT_W'(count - CNT_Q'(pop));
  assign headCol  = qCol[0];
  assign headSize = qSize[0];

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) qValid[i] = (CNT_Q'(i) < count);
  end

  // occupancy and burst position of the head request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      burstIdx <= '0;
    end else begin
      count <= count + CNT_Q'(push) - CNT_Q'(pop);
      if (pop)                   burstIdx <= '0;
      else if (strobe.nextBurst) burstIdx <= burstIdx + BURST_W'(1);
    end
  end

  // request storage: shift up on retire, append behind the survivors
  always_ff @(posedge clk) begin
    if (pop) begin
      for (int i = 0; i < QDEPTH - 1; i++) begin
        qBank[i] <= qBank[i+1];
        qRow[i]  <= qRow[i+1];
        qCol[i]  <= qCol[i+1];
        qSize[i] <= qSize[i+1];
      end
    end
    if (push) begin
      qBank[pushIdx] <= reqBank;
      qRow[pushIdx]  <= reqRow;
      qCol[pushIdx]  <= reqCol;
      qSize[pushIdx] <= reqSize;
    end
  end

  // device-wide spacing timers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdCnt <= '0;
      ccdCnt <= '0;
    end else begin
      if (rrdCnt != '0) rrdCnt <= rrdCnt - CNT_W'(1);
      if (ccdCnt != '0) ccdCnt <= ccdCnt - CNT_W'(1);
      if (strobe.kind == CMD_ACT)  rrdCnt <= CNT_W'(T_RRD - 1);
      if (strobe.kind == CMD_READ) ccdCnt <= CNT_W'(T_CCD - 1);
    end
  end

  // per-bank row state and timers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic             isOpen;
    logic [ROW_W-1:0] openRow;
    logic [CNT_W-1:0] rpCnt, rcdCnt, rasCnt;
    logic             selB;

    assign selB = (strobe.bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        isOpen  <= 1'b0;
        openRow <= '0;
        rpCnt   <= '0;
        rcdCnt  <= '0;
        rasCnt  <= '0;
      end else begin
        if (rpCnt  != '0) rpCnt  <= rpCnt  - CNT_W'(1);
        if (rcdCnt != '0) rcdCnt <= rcdCnt - CNT_W'(1);
        if (rasCnt != '0) rasCnt <= rasCnt - CNT_W'(1);
        if (selB && strobe.kind == CMD_PRE) begin
          isOpen <= 1'b0;
          rpCnt  <= CNT_W'(T_RP - 1);
        end
        if (selB && strobe.kind == CMD_ACT) begin
          isOpen  <= 1'b1;
          openRow <= qRow[slot];
          rcdCnt  <= CNT_W'(T_RCD - 1);
          rasCnt  <= CNT_W'(T_RAS - 1);
        end
      end
    end

    assign bankOpen[b] = isOpen;
    assign bankRow[b]  = openRow;
    assign actOk[b]    = (rpCnt == '0) && (rrdCnt == '0);
    assign readOk[b]   = (rcdCnt == '0) && (ccdCnt == '0);
    assign preOk[b]    = (rasCnt == '0);
  end
endmodule

// File: rtl/lasched_control.sv
module lasched_control
  import lasched_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int SLOT_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int BURST_LEN = 4
) (
  input  logic [QDEPTH-1:0]               qValid,
  input  logic [QDEPTH-1:0][BANK_W-1:0]   qBank,
  input  logic [QDEPTH-1:0][ROW_W-1:0]    qRow,
  input  logic [COL_W-1:0]                headCol,
  input  logic [SIZE_W-1:0]               headSize,
  input  logic [BURST_W-1:0]              burstIdx,
  input  logic [NUM_BANKS-1:0]            bankOpen,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] bankRow,
  input  logic [NUM_BANKS-1:0]            actOk,
  input  logic [NUM_BANKS-1:0]            readOk,
  input  logic [NUM_BANKS-1:0]            preOk,
  output strobe_t                         strobe,
  output logic [SLOT_W-1:0]               slot,
  output logic [2:0]                      cmdCode,
  output logic [BANK_W-1:0]               cmdBank,
  output logic [ADDR_W-1:0]               cmdAddr
);
  cmd_e             need     [QDEPTH];
  logic             legal    [QDEPTH];
  logic             shadowed [QDEPTH];
  logic             found;
  cmd_e             kind;
  logic [COL_W-1:0] colNow;

  // next command and its legality for every entry
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      if (bankOpen[qBank[i]] && bankRow[qBank[i]] == qRow[i]) begin
        need[i]  = CMD_READ;
        legal[i] = readOk[qBank[i]];
      end else if (bankOpen[qBank[i]]) begin
        need[i]  = CMD_PRE;
        legal[i] = preOk[qBank[i]];
      end else begin
        need[i]  = CMD_ACT;
        legal[i] = actOk[qBank[i]];
      end
      shadowed[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (qBank[j] == qBank[i]) shadowed[i] = 1'b1;
      end
    end
  end

  // head first, then the oldest younger entry that can take row preparation
  always_comb begin
    found = 1'b0;
    slot  = '0;
    if (qValid[0] && legal[0]) begin
      found = 1'b1;
    end else begin
      for (int i = 1; i < QDEPTH; i++) begin
        if (!found && qValid[i] && need[i] != CMD_READ && legal[i] && !shadowed[i]) begin
          found = 1'b1;
          slot  = SLOT_W'(i);
        end
      end
    end
  end

  assign kind   = found ? need[slot] : CMD_NOP;
  assign colNow = headCol + COL_W'(int'(burstIdx) * BURST_LEN);

  always_comb begin
    cmdCode = kind;
    cmdBank = found ? qBank[slot] : '0;
    case (kind)
      CMD_ACT:  cmdAddr = ADDR_W'(qRow[slot]);
      CMD_READ: cmdAddr = ADDR_W'(colNow);
      default:  cmdAddr = '0;
    endcase
  end

  always_comb begin
    strobe.kind      = kind;
    strobe.bank      = cmdBank;
    strobe.nextBurst = (kind == CMD_READ);
    strobe.pop       = (kind == CMD_READ) &&
                       (burstIdx == BURST_W'((1 << headSize) - 1));
  end
endmodule

// File: rtl/lookahead_cmd_sched.sv
module lookahead_cmd_sched
  import lasched_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      reqValid,
  output logic                                      reqReady,
  input  logic [BANK_W-1:0]                         reqBank,
  input  logic [ROW_W-1:0]                          reqRow,
  input  logic [COL_W-1:0]                          reqCol,
  input  logic [SIZE_W-1:0]                         reqSize,
  output logic [2:0]                                cmdCode,
  output logic [BANK_W-1:0]                         cmdBank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmdAddr
);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int SLOT_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int T_CCD  = BURST_LEN / 2;

  strobe_t                         strobe;
  logic [SLOT_W-1:0]               slot;
  logic [QDEPTH-1:0]               qValid;
  logic [QDEPTH-1:0][BANK_W-1:0]   qBank;
  logic [QDEPTH-1:0][ROW_W-1:0]    qRow;
  logic [COL_W-1:0]                headCol;
  logic [SIZE_W-1:0]               headSize;
  logic [BURST_W-1:0]              burstIdx;
  logic [NUM_BANKS-1:0]            bankOpen, actOk, readOk, preOk;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bankRow;

  lasched_datapath #(
    .QDEPTH(QDEPTH), .SLOT_W(SLOT_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RRD(T_RRD), .T_CCD(T_CCD)
  ) uPath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqSize(reqSize),
    .strobe(strobe), .slot(slot), .qValid(qValid), .qBank(qBank), .qRow(qRow),
    .headCol(headCol), .headSize(headSize), .burstIdx(burstIdx),
    .bankOpen(bankOpen), .bankRow(bankRow), .actOk(actOk), .readOk(readOk), .preOk(preOk)
  );

  lasched_control #(
    .QDEPTH(QDEPTH), .SLOT_W(SLOT_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)
  ) uCtrl (
    .qValid(qValid), .qBank(qBank), .qRow(qRow), .headCol(headCol), .headSize(headSize),
    .burstIdx(burstIdx), .bankOpen(bankOpen), .bankRow(bankRow), .actOk(actOk),
    .readOk(readOk), .preOk(preOk), .strobe(strobe), .slot(slot),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );
endmodule

// File: rtl/lasched_checker.sv
module lasched_checker
  import lasched_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 6,
  parameter int T_RRD  = 2,
  parameter int T_CCD  = 2,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cmdCode,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ADDR_W-1:0] cmdAddr
);
  logic [7:0]           sinceRead, sinceActAny;
  logic [7:0]           sincePre [NUM_BANKS];
  logic [7:0]           sinceAct [NUM_BANKS];
  logic [NUM_BANKS-1:0] seenOpen;

  function automatic logic [7:0] bump(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRead   <= 8'hFF;
      sinceActAny <= 8'hFF;
      seenOpen    <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        sincePre[b] <= 8'hFF;
        sinceAct[b] <= 8'hFF;
      end
    end else begin
      sinceRead   <= (cmdCode == CMD_READ) ? 8'd1 : bump(sinceRead);
      sinceActAny <= (cmdCode == CMD_ACT)  ? 8'd1 : bump(sinceActAny);
      for (int b = 0; b < NUM_BANKS; b++) begin
        sincePre[b] <= (cmdCode == CMD_PRE && cmdBank == BANK_W'(b)) ? 8'd1 : bump(sincePre[b]);
        sinceAct[b] <= (cmdCode == CMD_ACT && cmdBank == BANK_W'(b)) ? 8'd1 : bump(sinceAct[b]);
        if (cmdCode == CMD_ACT && cmdBank == BANK_W'(b)) seenOpen[b] <= 1'b1;
        if (cmdCode == CMD_PRE && cmdBank == BANK_W'(b)) seenOpen[b] <= 1'b0;
      end
    end
  end

  a_r3_pre_to_act: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_ACT |-> int'(sincePre[cmdBank]) >= T_RP);
  a_r3_act_to_read: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_READ |-> int'(sinceAct[cmdBank]) >= T_RCD);
  a_r3_act_to_pre: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_PRE |-> int'(sinceAct[cmdBank]) >= T_RAS);
  a_r4_act_spacing: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_ACT |-> int'(sinceActAny) >= T_RRD);
  a_r5_read_spacing: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_READ |-> int'(sinceRead) >= T_CCD);
  a_r2_read_on_open: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_READ |-> seenOpen[cmdBank]);
  a_r2_act_on_closed: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_ACT |-> !seenOpen[cmdBank]);
  a_r2_pre_on_open: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_PRE |-> seenOpen[cmdBank]);
  a_r12_code_range: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode <= 3'd3);
  a_r12_nop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == CMD_NOP |-> (cmdBank == '0 && cmdAddr == '0));
endmodule

bind lookahead_cmd_sched lasched_checker #(
  .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RRD(T_RRD),
  .T_CCD(BURST_LEN / 2), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
);

// File: tb/sim_lookahead_cmd_sched.sv
module sim_lookahead_cmd_sched;
  localparam int QD = 4, RW = 13, CW = 10;
  localparam int TRP = 3, TRCD = 3, TRAS = 6, TRRD = 2, BL = 4, TCCD = BL / 2;
  localparam int MAXCYC = 5000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, reqValid, reqReady;
  logic [1:0]    reqBank, reqSize, cmdBank;
  logic [RW-1:0] reqRow, cmdAddr;
  logic [CW-1:0] reqCol;
  logic [2:0]    cmdCode;

  lookahead_cmd_sched #(.QDEPTH(QD), .ROW_W(RW), .COL_W(CW), .T_RP(TRP), .T_RCD(TRCD),
    .T_RAS(TRAS), .T_RRD(TRRD), .BURST_LEN(BL)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqSize(reqSize), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr));

  typedef struct {int bank; int row; int col; int size;} req_t;
  req_t stim[$];
  req_t mq[$];
  int   expBank[$], expRow[$], expAddr[$], expFirst[$];

  int checks = 0, errors = 0;
  int now = 0, mBurst = 0, lookaheads = 0, fullSeen = 0;
  bit mOpen[4]; int mRow[4], mPre[4], mAct[4]; int mActAny, mRead;
  bit oOpen[4]; int oRow[4], oPre[4], oAct[4]; int oActAny, oRead;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic addReq(input int b, input int r, input int c, input int s);
    req_t x; x.bank = b; x.row = r; x.col = c; x.size = s;
    stim.push_back(x);
  endtask

  // 0 NOP, 1 ACT, 2 READ, 3 PRE
  function automatic int mNeed(input req_t r);
    if (mOpen[r.bank] && mRow[r.bank] == r.row) return 2;
    if (mOpen[r.bank]) return 3;
    return 1;
  endfunction

  function automatic bit mLegal(input int k, input int b);
    if (k == 1) return (now - mPre[b] >= TRP) && (now - mActAny >= TRRD);
    if (k == 2) return (now - mAct[b] >= TRCD) && (now - mRead >= TCCD);
    return (now - mAct[b] >= TRAS);
  endfunction

  task automatic mDecide(output int kind, output int bank, output int addr,
                         output int slot, output string tag);
    kind = 0; bank = 0; addr = 0; slot = -1; tag = "R3";
    if (mq.size() > 0 && mLegal(mNeed(mq[0]), mq[0].bank)) begin
      slot = 0;
      tag = (mNeed(mq[0]) == 2) ? "R1" : "R7";
    end else begin
      for (int i = 1; i < mq.size(); i++) begin
        bit older = 0;
        for (int j = 0; j < i; j++) if (mq[j].bank == mq[i].bank) older = 1;
        if (slot < 0 && !older && mNeed(mq[i]) != 2 && mLegal(mNeed(mq[i]), mq[i].bank)) begin
          slot = i; tag = "R8";
        end
      end
    end
    if (slot >= 0) begin
      kind = mNeed(mq[slot]);
      bank = mq[slot].bank;
      if (kind == 1) addr = mq[slot].row;
      if (kind == 2) addr = (mq[0].col + mBurst * BL) % (1 << CW);
    end
  endtask

  initial begin
    int kind, bank, addr, slot, idle, cyc;
    string tag;
    bit accept;
    for (int b = 0; b < 4; b++) begin
      mOpen[b] = 0; mRow[b] = 0; mPre[b] = -1000; mAct[b] = -1000;
      oOpen[b] = 0; oRow[b] = 0; oPre[b] = -1000; oAct[b] = -1000;
    end
    mActAny = -1000; mRead = -1000; oActAny = -1000; oRead = -1000;
    // open a row in every bank
    addReq(0, 5, 0, 0);   addReq(1, 7, 8, 0);   addReq(2, 9, 16, 0);  addReq(3, 11, 24, 0);
    // mix of hits and misses over four banks
    addReq(0, 6, 32, 1);  addReq(1, 7, 40, 2);  addReq(2, 3, 48, 0);  addReq(3, 2, 56, 1);
    // same-bank misses back to back, long transfer, more hits and misses
    addReq(1, 20, 0, 0);  addReq(1, 21, 4, 1);  addReq(1, 21, 64, 3); addReq(2, 3, 100, 2);
    addReq(0, 6, 12, 0);  addReq(3, 2, 200, 1); addReq(0, 40, 0, 2);  addReq(2, 50, 8, 1);
    addReq(0, 40, 300, 0); addReq(3, 9, 20, 3);

    rstN = 1'b0; reqValid = 1'b0; reqBank = '0; reqRow = '0; reqCol = '0; reqSize = '0;
    repeat (3) @(negedge clk);
    check(cmdCode == 3'd0, "R11", "cmd in reset", cmdCode, 0);
    check(reqReady == 1'b1, "R11", "ready in reset", reqReady, 1);
    check(cmdAddr == '0, "R11", "addr in reset", cmdAddr, 0);
    rstN = 1'b1;

    idle = 0; cyc = 0;
    while (cyc < MAXCYC && !(stim.size() == 0 && mq.size() == 0 && idle >= 8)) begin
      if (stim.size() > 0 && (cyc % 7) != 6) begin
        reqValid = 1'b1;
        reqBank = 2'(stim[0].bank); reqRow = RW'(stim[0].row);
        reqCol = CW'(stim[0].col);  reqSize = 2'(stim[0].size);
      end else begin
        reqValid = 1'b0;
      end
      #1;
      mDecide(kind, bank, addr, slot, tag);
      check(int'(cmdCode) == kind, tag, "cmd", cmdCode, kind);
      check(int'(cmdBank) == bank, tag, "bank", cmdBank, bank);
      check(int'(cmdAddr) == addr, (kind == 0) ? "R12" : tag, "addr", cmdAddr, addr);
      check(reqReady == (mq.size() < QD), "R10", "ready", reqReady, mq.size() < QD);
      check(cmdCode <= 3'd3, "R12", "code range", cmdCode, 3);
      if (mq.size() == QD) fullSeen++;

      // observed-command monitor, independent of the model's choices
      if (cmdCode == 3'd1) begin
        check(now - oPre[cmdBank] >= TRP, "R3", "PRE->ACT gap", now - oPre[cmdBank], TRP);
        check(now - oActAny >= TRRD, "R4", "ACT->ACT gap", now - oActAny, TRRD);
        check(!oOpen[cmdBank], "R2", "ACT on open bank", oOpen[cmdBank], 0);
        oOpen[cmdBank] = 1; oRow[cmdBank] = int'(cmdAddr);
        oAct[cmdBank] = now; oActAny = now;
      end else if (cmdCode == 3'd3) begin
        check(now - oAct[cmdBank] >= TRAS, "R3", "ACT->PRE gap", now - oAct[cmdBank], TRAS);
        check(oOpen[cmdBank], "R2", "PRE on closed bank", oOpen[cmdBank], 1);
        oOpen[cmdBank] = 0; oPre[cmdBank] = now;
      end else if (cmdCode == 3'd2) begin
        check(now - oRead >= TCCD, "R5", "READ gap", now - oRead, TCCD);
        check(now - oAct[cmdBank] >= TRCD, "R3", "ACT->READ gap", now - oAct[cmdBank], TRCD);
        if (expBank.size() > 0) begin
          check(int'(cmdBank) == expBank[0], "R9", "READ bank order", cmdBank, expBank[0]);
          check(int'(cmdAddr) == expAddr[0], "R6", "READ column", cmdAddr, expAddr[0]);
          check(oOpen[cmdBank] && oRow[cmdBank] == expRow[0], "R2", "READ row open",
                oRow[cmdBank], expRow[0]);
          if (expFirst[0] == 0)
            check(now - oRead == TCCD, "R5", "burst spacing", now - oRead, TCCD);
          void'(expBank.pop_front()); void'(expAddr.pop_front());
          void'(expRow.pop_front());  void'(expFirst.pop_front());
        end else begin
          check(1'b0, "R9", "READ with none expected", cmdBank, -1);
        end
        oRead = now;
      end

      accept = reqValid && reqReady;
      @(posedge clk);
      // reference model update for the command of this cycle
      if (kind == 3) begin mOpen[bank] = 0; mPre[bank] = now; end
      if (kind == 1) begin mOpen[bank] = 1; mRow[bank] = addr; mAct[bank] = now; mActAny = now; end
      if (kind != 0 && slot > 0) lookaheads++;
      if (kind == 2) begin
        mRead = now;
        mBurst++;
        if (mBurst == (1 << mq[0].size)) begin
          mBurst = 0;
          void'(mq.pop_front());
        end
      end
      if (accept) begin
        mq.push_back(stim[0]);
        for (int k = 0; k < (1 << stim[0].size); k++) begin
          expBank.push_back(stim[0].bank);
          expRow.push_back(stim[0].row);
          expAddr.push_back((stim[0].col + k * BL) % (1 << CW));
          expFirst.push_back(k == 0);
        end
        void'(stim.pop_front());
      end
      now++;
      cyc++;
      if (stim.size() == 0 && mq.size() == 0) idle++;
      @(negedge clk);
    end

    if (cyc >= MAXCYC) check(1'b0, "watchdog", "run did not finish", cyc, MAXCYC);
    check(expBank.size() == 0, "R6", "READ bursts left over", expBank.size(), 0);
    check(lookaheads > 0, "R8", "advance commands issued", lookaheads, 1);
    check(fullSeen > 0, "R10", "queue reached four", fullSeen, 1);
    check(cmdCode == 3'd0, "R12", "idle NOP", cmdCode, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule